// File: doc/BRIEF.md
# Retry Timeout Watchdog and Status Register

This block watches two independent bus sides of a bridge, the primary side and the card side. On each side, the bridge may tell a requesting master to retry. The block then measures how long that master takes to come back. If the master has not returned within a window of 2^15 clock cycles, the block raises a sticky "retry expired" flag for that side.

Both watchdogs report through one 8-bit control and status register. Two of its bits are read/write enables, one per side. Two bits are sticky expiry flags that software clears by writing a 1 to them. The other four bits are fixed at zero. Software reaches the register through a port with a one-cycle write strobe, 8 bits of write data and a combinational 8-bit read value. Address decoding sits outside the block: in the configuration space the register is placed at offset 0x90.

Each side runs a three-state machine with the states `IDLE`, `COUNT` and `EXPIRED`. The transitions are:
- `IDLE`→`COUNT` on a retry-issued pulse. The count loads zero.
- `COUNT`→`IDLE` on a master-returned pulse.
- `COUNT`→`EXPIRED` when the count reaches 2^15-1. This transition sets the side's flag.
- `EXPIRED`→`COUNT` on the next retry-issued pulse.
- Any state goes to `IDLE` whenever the side's enable bit is 0.

Top module: `retry_timeout_status`

## Requirements
- R1: Out of reset the register reads 0xC0: both enables are 1 and both flags are 0.
- R2: Bit 7 is the primary-side enable and bit 6 is the card-side enable. Both are written by any register write and read back as written.
- R3: Bits 5, 4, 2 and 0 always read 0, whatever value is written.
- R4: A retry-issued pulse sampled while the side is idle starts its count. The side's flag (bit 1 for primary, bit 3 for card) reads 1 exactly 32767 clock edges after the edge that sampled the pulse, and still reads 0 one edge earlier.
- R5: A master-returned pulse before expiry stops the count with no flag set. A later retry-issued pulse counts a full new window from zero.
- R6: A retry-issued pulse that arrives while the side is already counting is ignored. The window keeps running from the first pulse.
- R7: Writing 1 to a flag bit clears it. Writing 0 to a flag bit leaves it unchanged.
- R8: When the hardware sets a flag in the same cycle that software writes 1 to clear it, the flag ends up set.
- R9: While a side's enable is 0 its count is held cleared. Disabling a side in the middle of a count abandons that count, so no flag is set later from it.
- R10: After expiry a side stops counting. Its flag stays set until cleared, even if a master-returned pulse arrives, and the side does not expire again without a new retry-issued pulse.
- R11: The two sides count and flag independently and may expire in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pri_retry_issued | input | 1 | One-cycle pulse: the primary side told a master to retry |
| pri_master_back | input | 1 | One-cycle pulse: the primary-side master returned |
| card_retry_issued | input | 1 | One-cycle pulse: the card side told a master to retry |
| card_master_back | input | 1 | One-cycle pulse: the card-side master returned |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |

## Verification
The hardest situation to reach from the ports is the exact cycle in which a count hits its terminal value. Proving the one-edge boundary of R4 depends on it. So does proving that a software clear and the hardware set in that same cycle resolve to set (R8). The bench counts falling edges from the edge that sampled the retry pulse and checks the read value one edge before the terminal edge and at it. For the collision case it holds a write-1-to-clear strobe across exactly that terminal edge. The same long waits are reused to show three further behaviours: an ignored second retry, a restart after a master returns, and a disabled side that never expires.

// File: rtl/retry_timeout_pkg.sv
package retry_timeout_pkg;

    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_COUNT   = 2'd1,
        WD_EXPIRED = 2'd2
    } wd_state_t;

    localparam int unsigned REG_W        = 8;
    localparam int unsigned PRI_EN_BIT   = 7;
    localparam int unsigned CARD_EN_BIT  = 6;
    localparam int unsigned CARD_EXP_BIT = 3;
    localparam int unsigned PRI_EXP_BIT  = 1;
    localparam logic [REG_W-1:0] RESET_VAL = 8'hC0;
    localparam logic [REG_W-1:0] ZERO_MASK = 8'b0011_0101;

endpackage

// File: rtl/retry_watchdog.sv
module retry_watchdog
    import retry_timeout_pkg::*;
#(
    parameter int unsigned CNT_W = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic retry_issued,
    input  logic master_back,
    output logic expire_set
);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;
    localparam logic [CNT_W-1:0] CNT_PRE  = CNT_LAST - 1'b1;

    wd_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = WD_IDLE;
        end else begin
            unique case (state_q)
                WD_IDLE:    if (retry_issued) state_d = WD_COUNT;
                WD_COUNT: begin
                    if (master_back)           state_d = WD_IDLE;
                    else if (cnt_q == CNT_PRE) state_d = WD_EXPIRED;
                end
                WD_EXPIRED: if (retry_issued) state_d = WD_COUNT;
                default:    state_d = WD_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_IDLE;
        else        state_q <= state_d;
    end

    // counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (state_d == WD_COUNT && state_q != WD_COUNT) begin
            cnt_q <= '0;
        end else if (state_q == WD_COUNT && state_d != WD_IDLE) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (state_d == WD_IDLE) begin
            cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        expire_set = (state_q == WD_COUNT) && (state_d == WD_EXPIRED);
    end

    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_q == WD_IDLE && cnt_q == '0));

    a_r4_expire_at_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        expire_set |-> (enable && cnt_q == CNT_PRE && !master_back));

    a_r6_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_COUNT && enable && !master_back) |=> cnt_q == $past(cnt_q) + 1'b1);

    a_r10_expired_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_EXPIRED && enable && !retry_issued) |=> (state_q == WD_EXPIRED && $stable(cnt_q)));

endmodule

// File: rtl/retry_status_regs.sv
module retry_status_regs
    import retry_timeout_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             pri_set,
    input  logic             card_set,
    output logic             pri_enable,
    output logic             card_enable,
    output logic [REG_W-1:0] rd_data
);
    logic pri_flag_q, card_flag_q;
    logic pri_clr, card_clr;

    always_comb begin
        pri_clr  = wr_en && wr_data[PRI_EXP_BIT];
        card_clr = wr_en && wr_data[CARD_EXP_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_enable  <= RESET_VAL[PRI_EN_BIT];
            card_enable <= RESET_VAL[CARD_EN_BIT];
        end else if (wr_en) begin
            pri_enable  <= wr_data[PRI_EN_BIT];
            card_enable <= wr_data[CARD_EN_BIT];
        end
    end

    // set has priority over write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_flag_q  <= 1'b0;
            card_flag_q <= 1'b0;
        end else begin
            pri_flag_q  <= pri_set  | (pri_flag_q  & ~pri_clr);
            card_flag_q <= card_set | (card_flag_q & ~card_clr);
        end
    end

    always_comb begin
        rd_data               = '0;
        rd_data[PRI_EN_BIT]   = pri_enable;
        rd_data[CARD_EN_BIT]  = card_enable;
        rd_data[PRI_EXP_BIT]  = pri_flag_q;
        rd_data[CARD_EXP_BIT] = card_flag_q;
    end

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ZERO_MASK) == '0);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_set || card_set) |=> ((!$past(pri_set) || pri_flag_q) && (!$past(card_set) || card_flag_q)));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_flag_q && !pri_clr) |=> pri_flag_q);

    a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (card_clr && !card_set) |=> !card_flag_q);

endmodule

// File: rtl/retry_timeout_status.sv
module retry_timeout_status
    import retry_timeout_pkg::*;
#(
    parameter int unsigned CNT_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pri_retry_issued,
    input  logic       pri_master_back,
    input  logic       card_retry_issued,
    input  logic       card_master_back,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);
    localparam int unsigned N_SIDE = 2;

    logic [N_SIDE-1:0] side_en, side_retry, side_back, side_expire;

    always_comb begin
        side_retry = {card_retry_issued, pri_retry_issued};
        side_back  = {card_master_back,  pri_master_back};
    end

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        retry_watchdog #(.CNT_W(CNT_W)) i_wd (
            .clk          (clk),
            .rst_n        (rst_n),
            .enable       (side_en[s]),
            .retry_issued (side_retry[s]),
            .master_back  (side_back[s]),
            .expire_set   (side_expire[s])
        );
    end

    retry_status_regs i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .wr_data     (reg_wdata),
        .pri_set     (side_expire[0]),
        .card_set    (side_expire[1]),
        .pri_enable  (side_en[0]),
        .card_enable (side_en[1]),
        .rd_data     (reg_rdata)
    );

    a_r11_expire_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(side_expire & ~side_en) == 0);

endmodule

// File: tb/test_retry_timeout_status.sv
module test_retry_timeout_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pri_retry_issued = 1'b0, pri_master_back = 1'b0;
    logic       card_retry_issued = 1'b0, card_master_back = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    retry_timeout_status i_retry_timeout_status (.*);

    task automatic check(input string req, input logic [7:0] exp);
        n_chk++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: rdata=%02h expected=%02h", req, reg_rdata, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic t_reset;
        check("R1 in reset", 8'hC0);
        rst_n = 1'b1;
        wait_n(2);
        check("R1 after reset", 8'hC0);
    endtask

    task automatic t_enable_rw;
        wr(8'h00); check("R2 both off", 8'h00);
        wr(8'h80); check("R2 primary on", 8'h80);
        wr(8'h40); check("R2 card on", 8'h40);
        wr(8'hFF); check("R3 reserved ignore", 8'hC0);
    endtask

    // R4 R6 R11: both sides start together; extra primary retry ignored
    task automatic t_expiry_both;
        pri_retry_issued = 1'b1; card_retry_issued = 1'b1;
        @(negedge clk);
        pri_retry_issued = 1'b0; card_retry_issued = 1'b0;
        wait_n(100);
        pri_retry_issued = 1'b1;
        @(negedge clk);
        pri_retry_issued = 1'b0;
        wait_n(32766 - 101);
        check("R4 one edge early", 8'hC0);
        wait_n(1);
        check("R4 R6 R11 both expired", 8'hCA);
        pri_master_back = 1'b1; card_master_back = 1'b1;
        @(negedge clk);
        pri_master_back = 1'b0; card_master_back = 1'b0;
        check("R10 return after expiry", 8'hCA);
    endtask

    task automatic t_clear;
        wr(8'hC0); check("R7 write zero keeps", 8'hCA);
        wr(8'hC8); check("R7 clear card", 8'hC2);
        wr(8'hC2); check("R7 clear primary", 8'hC0);
    endtask

    // R5 restart; R10 card stays stopped after expiry
    task automatic t_return;
        pri_retry_issued = 1'b1; @(negedge clk); pri_retry_issued = 1'b0;
        wait_n(999);
        pri_master_back = 1'b1; @(negedge clk); pri_master_back = 1'b0;
        wait_n(100);
        check("R5 no flag on return", 8'hC0);
        pri_retry_issued = 1'b1; @(negedge clk); pri_retry_issued = 1'b0;
        wait_n(32766);
        check("R5 R10 restart from zero", 8'hC0);
        wait_n(1);
        check("R5 expired after new window", 8'hC2);
        wr(8'hC2);
        check("R7 cleared", 8'hC0);
    endtask

    // R8 collision on primary; R9 card disabled mid-count
    task automatic t_collision;
        pri_retry_issued = 1'b1; card_retry_issued = 1'b1;
        @(negedge clk);
        pri_retry_issued = 1'b0; card_retry_issued = 1'b0;
        wait_n(500);
        wr(8'h80);
        check("R9 card disabled", 8'h80);
        wr(8'hC0);
        wait_n(32766 - 502);
        reg_wr = 1'b1; reg_wdata = 8'hC2;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00;
        check("R8 R9 set wins card silent", 8'hC2);
        wait_n(50);
        check("R9 card never expires", 8'hC2);
        wr(8'hC2);
        check("R7 final clear", 8'hC0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_enable_rw();
        t_expiry_both();
        t_clear();
        t_return();
        t_collision();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: run hung, expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule